// File: doc/BRIEF.md
# Dual-Rail Power-Up Reset Sequencer

This block produces the system reset for a device fed by two supply rails. Each rail has an analog comparator that reports when the rail is under its reset threshold. Those reports reach the block asynchronously. The block synchronizes them to the oscillator clock and keeps reset asserted while any rail is reported low. Once every rail is good, it counts a fixed warm-up interval of oscillator clocks and then releases reset.

A rail dip during the warm-up sends the sequencer back to its holding state, and the full count starts again. After release, a rail dip asserts reset again. The one exception is when the device is in stop mode with the bandgap reference switched off. In that case the comparators cannot be trusted, so rail reports do not cause a power-fail reset.

The sequencer has three states: holding, warming up and running. Reset is a registered, active-high output derived from the next state, so it carries no combinational glitches. The warm-up length and the synchronizer depth are parameters. A short warm-up suits simulation, and the default is 65536 clocks.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `cold_n` is 0, `sys_rst` is 1, whatever the rail inputs are.
- R2: Before release, `sys_rst` stays 1 for as long as any bit of `rail_low` is 1 after synchronization (bit i = 1 means rail i is under its reset threshold).
- R3: When every `rail_low` bit goes to 0 and stays there, `sys_rst` falls exactly SYNC_STAGES + 1 + WARMUP_CYCLES rising clock edges after the first edge that samples all rails good.
- R4: A rail reported low for even one sampled cycle during the warm-up restarts it. Release then comes the full R3 interval after the rails are good again.
- R5: After release, a `rail_low` bit going to 1 sets `sys_rst` to 1 on the SYNC_STAGES + 1 edge after it is first sampled. This holds unless the stop-mode exception of R6 applies.
- R6: After release, while `stop_mode` = 1 and `bg_sel` = 0 (bandgap off), rail reports have no effect and `sys_rst` stays 0.
- R7: With `stop_mode` = 1 and `bg_sel` = 1 (bandgap on), a rail report after release asserts reset as in R5.
- R8: The stop-mode exception applies only after release. Before release, rail reports keep reset held and restart the warm-up even when `stop_mode` = 1 and `bg_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| cold_n | input | 1 | Asynchronous clear from the supply ramp detector, active low |
| rail_low | input | NUM_RAILS | Per-rail comparator output, 1 = rail under reset threshold (asynchronous) |
| stop_mode | input | 1 | 1 while the device is in stop mode |
| bg_sel | input | 1 | Bandgap select, 1 = reference kept on in stop mode |
| sys_rst | output | 1 | Registered system reset, active high |

## Verification
The bench builds the block with WARMUP_CYCLES = 40 and SYNC_STAGES = 2. With these values, hundreds of complete release sequences fit in one run. Dips at every warm-up position, dips straddling the release edge, and repeated blind and non-blind stop episodes all come within reach. Directed cases check the exact release and reassertion edges. A cycle model, written from the requirements, follows random rail dips and stop/bandgap changes.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [1:0] {
      ST_HOLD   = 2'd0,
      ST_WARMUP = 2'd1,
      ST_RUN    = 2'd2
   } rsq_state_e;

endpackage

// File: rtl/rsq_sync.sv
// Multi-bit synchronizer; every bit is an independent asynchronous input.
// Resets to the fail-safe value so that a fresh power-up sees every rail low.
module rsq_sync #(
   parameter int   WIDTH    = 2,
   parameter int   STAGES   = 2,
   parameter logic SAFE_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] chain_q;

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               chain_q <= {STAGES{ {WIDTH{SAFE_VAL}} }};
            end else begin
               chain_q[0] <= d;
               for (int s = 1; s < STAGES; s++) begin
                  chain_q[s] <= chain_q[s-1];
               end
            end
         end

         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rsq_fault_mon.sv
// Combines synchronized rail reports and applies the stop-mode blinding.
module rsq_fault_mon #(
   parameter int NUM_RAILS    = 2,
   parameter bit STOP_BLINDS  = 1'b1
) (
   input  logic [NUM_RAILS-1:0] rail_low_s,
   input  logic                 stop_mode,
   input  logic                 bg_sel,
   output logic                 any_low,
   output logic                 pf_fault
);

   logic blind;

   assign any_low = |rail_low_s;

   generate
      if (STOP_BLINDS) begin : g_blind
         assign blind = stop_mode & ~bg_sel;
      end else begin : g_never_blind
         assign blind = 1'b0;
      end
   endgenerate

   assign pf_fault = any_low & ~blind;

endmodule

// File: rtl/rsq_warmup_ctr.sv
// Warm-up counter: done flags the last count of the interval.
module rsq_warmup_ctr #(
   parameter int CYCLES = 65536
) (
   input  logic clk,
   input  logic arst_n,
   input  logic clr,
   input  logic en,
   output logic done
);

   localparam int            CW   = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == LAST);

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
   parameter int NUM_RAILS     = 2,
   parameter int WARMUP_CYCLES = 65536,
   parameter int SYNC_STAGES   = 2,
   parameter bit STOP_BLINDS   = 1'b1
) (
   input  logic                 osc_clk,
   input  logic                 cold_n,
   input  logic [NUM_RAILS-1:0] rail_low,
   input  logic                 stop_mode,
   input  logic                 bg_sel,
   output logic                 sys_rst
);

   import rsq_pkg::*;

   generate
      if (NUM_RAILS < 1) begin : g_bad_rails
         $error("pwr_rst_seq: NUM_RAILS must be at least 1");
      end
      if (WARMUP_CYCLES < 2) begin : g_bad_warmup
         $error("pwr_rst_seq: WARMUP_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("pwr_rst_seq: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [NUM_RAILS-1:0] rail_low_s;
   logic                 any_low;
   logic                 pf_fault;
   logic                 ctr_clr;
   logic                 ctr_en;
   logic                 ctr_done;
   rsq_state_e           state_q;
   rsq_state_e           state_d;
   logic                 rst_q;

   rsq_sync #(
      .WIDTH    (NUM_RAILS),
      .STAGES   (SYNC_STAGES),
      .SAFE_VAL (1'b1)
   ) u_sync (
      .clk    (osc_clk),
      .arst_n (cold_n),
      .d      (rail_low),
      .q      (rail_low_s)
   );

   rsq_fault_mon #(
      .NUM_RAILS   (NUM_RAILS),
      .STOP_BLINDS (STOP_BLINDS)
   ) u_mon (
      .rail_low_s (rail_low_s),
      .stop_mode  (stop_mode),
      .bg_sel     (bg_sel),
      .any_low    (any_low),
      .pf_fault   (pf_fault)
   );

   rsq_warmup_ctr #(
      .CYCLES (WARMUP_CYCLES)
   ) u_ctr (
      .clk    (osc_clk),
      .arst_n (cold_n),
      .clr    (ctr_clr),
      .en     (ctr_en),
      .done   (ctr_done)
   );

   always_comb begin
      state_d = state_q;
      ctr_clr = 1'b0;
      ctr_en  = 1'b0;
      unique case (state_q)
         ST_HOLD: begin
            ctr_clr = 1'b1;
            if (!any_low) state_d = ST_WARMUP;
         end
         ST_WARMUP: begin
            if (any_low) begin
               state_d = ST_HOLD;
               ctr_clr = 1'b1;
            end else if (ctr_done) begin
               state_d = ST_RUN;
            end else begin
               ctr_en = 1'b1;
            end
         end
         ST_RUN: begin
            ctr_clr = 1'b1;
            if (pf_fault) state_d = ST_HOLD;
         end
         default: begin
            state_d = ST_HOLD;
            ctr_clr = 1'b1;
         end
      endcase
   end

   always_ff @(posedge osc_clk or negedge cold_n) begin
      if (!cold_n) begin
         state_q <= ST_HOLD;
         rst_q   <= 1'b1;
      end else begin
         state_q <= state_d;
         rst_q   <= (state_d != ST_RUN);
      end
   end

   assign sys_rst = rst_q;

endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk #(
   parameter int NUM_RAILS = 2
) (
   input logic                 clk,
   input logic                 cold_n,
   input logic [NUM_RAILS-1:0] rail_low,
   input logic                 stop_mode,
   input logic                 bg_sel,
   input logic                 sys_rst,
   input logic                 any_low,
   input logic                 ctr_done,
   input rsq_pkg::rsq_state_e  state_q
);

   import rsq_pkg::*;

   logic blind;
   assign blind = stop_mode & ~bg_sel;

   always @(negedge clk) begin
      if (!cold_n) begin
         AST_COLD_HOLDS_RESET: assert (sys_rst === 1'b1); // R1
      end
   end

   AST_LOW_KEEPS_RESET: assert property (@(posedge clk) disable iff (!cold_n)
      (any_low && state_q != ST_RUN) |=> sys_rst); // R2

   AST_RELEASE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!cold_n)
      $fell(sys_rst) |-> $past(ctr_done)); // R3

   AST_WARMUP_RESTART: assert property (@(posedge clk) disable iff (!cold_n)
      (state_q == ST_WARMUP && any_low) |=> (state_q == ST_HOLD && sys_rst)); // R4

   AST_RUN_FAULT_RESETS: assert property (@(posedge clk) disable iff (!cold_n)
      (!sys_rst && any_low && !blind) |=> sys_rst); // R5

   AST_BLIND_NO_RESET: assert property (@(posedge clk) disable iff (!cold_n)
      (!sys_rst && blind) |=> !sys_rst); // R6

endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(
   .NUM_RAILS (NUM_RAILS)
) u_chk (
   .clk       (osc_clk),
   .cold_n    (cold_n),
   .rail_low  (rail_low),
   .stop_mode (stop_mode),
   .bg_sel    (bg_sel),
   .sys_rst   (sys_rst),
   .any_low   (any_low),
   .ctr_done  (ctr_done),
   .state_q   (state_q)
);

// File: tb/pwr_rst_seq_test.sv
module pwr_rst_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int NR         = 2;
   localparam int WU         = 40;
   localparam int SY         = 2;
   localparam int REL        = SY + 1 + WU;

   logic          clk = 1'b0;
   logic          cold_n;
   logic [NR-1:0] rail_low;
   logic          stop_mode;
   logic          bg_sel;
   logic          sys_rst;

   int checks   = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_rst_seq #(
      .NUM_RAILS     (NR),
      .WARMUP_CYCLES (WU),
      .SYNC_STAGES   (SY),
      .STOP_BLINDS   (1'b1)
   ) uut (
      .osc_clk   (osc_clk_w),
      .cold_n    (cold_n),
      .rail_low  (rail_low),
      .stop_mode (stop_mode),
      .bg_sel    (bg_sel),
      .sys_rst   (sys_rst)
   );

   wire osc_clk_w = clk;

   // Cycle model of the requirements: rail reports seen SY edges late,
   // release after WU+1 consecutive good edges, blinding only once released.
   logic [NR-1:0] mp0, mp1;
   int            good;
   logic          rel;

   function automatic logic is_blind(input logic stp, input logic bgs);
      return stp && !bgs;
   endfunction

   always @(posedge clk or negedge cold_n) begin
      if (!cold_n) begin
         mp0  <= '1;
         mp1  <= '1;
         good <= 0;
         rel  <= 1'b0;
      end else begin
         automatic logic f = |mp1;
         mp0 <= rail_low;
         mp1 <= mp0;
         if (rel) begin
            if (f && !is_blind(stop_mode, bg_sel)) begin
               rel  <= 1'b0;
               good <= 0;
            end
         end else if (f) begin
            good <= 0;
         end else if (good == WU) begin
            rel <= 1'b1;
         end else begin
            good <= good + 1;
         end
      end
   end

   task automatic check(input logic exp, input string tag);
      checks++;
      if (sys_rst !== exp) begin
         failures++;
         $display("FAIL %s: sys_rst=%0b expected=%0b at %0t", tag, sys_rst, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      cold_n    = 1'b0;
      rail_low  = '1;
      stop_mode = 1'b0;
      bg_sel    = 1'b0;
      step(3);
      check(1'b1, "R1 cold clear with rails low");
      rail_low = '0;
      step(REL + 5);
      check(1'b1, "R1 cold clear with rails good");

      rail_low = '1;
      step(1);
      cold_n = 1'b1;
      step(60);
      check(1'b1, "R2 both rails low");
      rail_low = 2'b10;
      step(60);
      check(1'b1, "R2 one rail low");

      rail_low = '0;
      step(REL - 1);
      check(1'b1, "R3 one edge before release");
      step(1);
      check(1'b0, "R3 release edge");

      rail_low = 2'b01;
      step(SY);
      check(1'b0, "R5 before reassertion");
      step(1);
      check(1'b1, "R5 reassertion edge");

      rail_low = '0;
      step(20);
      rail_low = 2'b10;
      step(1);
      rail_low = '0;
      step(REL - 1);
      check(1'b1, "R4 restart after one-cycle dip");
      step(1);
      check(1'b0, "R4 release after restart");

      stop_mode = 1'b1;
      bg_sel    = 1'b0;
      rail_low  = 2'b11;
      step(10);
      check(1'b0, "R6 blind stop ignores rail low");
      rail_low = '0;
      step(SY + 2);
      stop_mode = 1'b0;
      step(3);
      check(1'b0, "R6 no reset after blind episode");

      stop_mode = 1'b1;
      bg_sel    = 1'b1;
      rail_low  = 2'b01;
      step(SY + 1);
      check(1'b1, "R7 stop with bandgap on resets");

      bg_sel = 1'b0;
      step(30);
      check(1'b1, "R8 blind stop keeps reset held");
      rail_low = '0;
      step(15);
      rail_low = 2'b01;
      step(1);
      rail_low = '0;
      step(REL - 1);
      check(1'b1, "R8 blind dip restarts warm-up");
      step(1);
      check(1'b0, "R8 release after blind restart");
      stop_mode = 1'b0;
      step(2);

      begin
         int dip_left = 0;
         void'($urandom(32'h5eed_0123));
         for (int i = 0; i < 6000; i++) begin
            if (dip_left > 0) begin
               dip_left--;
               if (dip_left == 0) rail_low = '0;
            end else if ($urandom_range(0, 60) == 0) begin
               rail_low = ($urandom_range(0, 2) == 0) ? 2'b11 :
                          (($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10);
               dip_left = $urandom_range(1, 6);
            end
            if ($urandom_range(0, 150) == 0) stop_mode = ~stop_mode;
            if ($urandom_range(0, 90) == 0)  bg_sel    = ~bg_sel;
            step(1);
            check(!rel, "R3/R4/R5/R6 model compare");
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule